// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous pipelined static RAM. Its data phase follows the command by a fixed two enabled clocks in both directions, so reads and writes can be issued on consecutive clocks with no idle cycles between them. On each rising edge it decodes a command from these inputs:

- an active-low clock enable
- three chip-enable inputs
- an active-low address load strobe
- a read/write select
- four active-low byte write masks

A transfer is either a single word or a burst of up to four words. The burst takes its addresses from an internal counter.

The shared data bus is split into an input port, an output port and an output-enable flag. A two-stage pipeline carries each accepted operation until its data phase. Holding the clock enable high suspends the device: the whole pipeline freezes and the outputs keep their values.

Top module: `pipe_sram`

## Requirements
- R1: Chip enable is true only when `chipEn1N` is 0, `chipEn2` is 1 and `chipEn3N` is 0. Any other combination, sampled on an enabled edge with `loadN` low, starts a deselect. A deselect writes nothing and never drives the bus.
- R2: On an enabled edge with `loadN` low and chip enable true, a new access starts at `addr`. It is a read when `readNotWrite` is 1 and a write when it is 0.
- R3: For a read accepted on enabled edge E, the output register takes the word at the read address on the second enabled edge after E. `dqOe` is 1 from that same edge.
- R4: For a write accepted on enabled edge E, the word on `dqIn` and the masks on `byteWeN` are sampled on the second enabled edge after E. The array is updated on that edge.
- R5: An enabled edge with `loadN` high continues the current burst in the same direction. It uses the next address, which adds one to the two low address bits and wraps inside the aligned four-word group. `readNotWrite` and the chip enables are ignored on such an edge.
- R6: A continue that follows a deselect is itself a deselect.
- R7: An edge with `clkEnN` high is a suspend, and during a suspend:
  - no stage advances and the burst address is held;
  - no word is written;
  - `dqOut` and `dqOe` keep their values, so a read in progress keeps the bus driven and a write or deselect keeps it released.
- R8: Byte write mask bit i is active low and guards bits 9i+8 down to 9i. The masks are honoured independently on every write beat, including burst beats.
- R9: Reads and writes may alternate on consecutive enabled edges. When a write or deselect reaches the data phase, `dqOe` drops to 0 on that edge. A read issued right after a write to the same address returns the new word.
- R10: While `rst_n` is low, `dqOe` is 0 and the pipeline holds no operation. The first two data phases after reset therefore leave the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; high means suspend |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| loadN | input | 1 | Active-low address load; high continues the burst |
| readNotWrite | input | 1 | 1 selects read, 0 selects write |
| byteWeN | input | LANES (4) | Active-low byte write masks |
| addr | input | ADDR_W (6) | Word address |
| dqIn | input | LANES*LANE_W (36) | Write data from the shared bus |
| dqOut | output | LANES*LANE_W (36) | Registered read data |
| dqOe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a suspend in the middle of a burst that sits between the command and its data phase. In that state the data of an operation issued several edges earlier must neither advance nor be written, and the bus must keep its read value or stay released. The stimulus reaches it with bursts that start at every offset inside a group. Suspends are placed after the second beat, carry deliberately different data and masks, and are followed by continue beats whose direction and chip-enable inputs toggle. Separate sweeps cover back-to-back write-then-read of the same address, all sixteen byte masks, and each of the three deselect encodings followed by continues.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKindT;

  // Strobes from control to datapath for the operation in its data phase.
  typedef struct packed {
    logic advance;
    logic doRead;
    logic doWrite;
  } dpStrobeT;

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BEAT_BITS  = 2,
  parameter int PIPE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEnN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              loadN,
  input  logic              readNotWrite,
  input  logic [ADDR_W-1:0] addr,
  output dpStrobeT          strobes,
  output logic [ADDR_W-1:0] tailAddr
);

  localparam int LAST = PIPE_DEPTH - 1;

  typedef struct packed {
    opKindT            kind;
    logic [ADDR_W-1:0] a;
  } stageT;

  stageT stg [PIPE_DEPTH];

  logic              ceTrue;
  logic              advance;
  opKindT            issueKind;
  logic [ADDR_W-1:0] issueAddr;
  logic [BEAT_BITS-1:0] nextBeat;

  assign ceTrue  = !chipEn1N && chipEn2 && !chipEn3N;
  assign advance = !clkEnN;

  // Stage 0 doubles as the burst state: its kind and address are the last issued beat.
  assign nextBeat = stg[0].a[BEAT_BITS-1:0] + BEAT_BITS'(1);

  always_comb begin
    if (!loadN) begin
      issueAddr = addr;
      if (!ceTrue)           issueKind = OP_IDLE;
      else if (readNotWrite) issueKind = OP_READ;
      else                   issueKind = OP_WRITE;
    end else begin
      issueKind = stg[0].kind;
      issueAddr = {stg[0].a[ADDR_W-1:BEAT_BITS], nextBeat};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PIPE_DEPTH; i++) begin
        stg[i].kind <= OP_IDLE;
        stg[i].a    <= '0;
      end
    end else if (advance) begin
      stg[0].kind <= issueKind;
      stg[0].a    <= issueAddr;
      for (int i = 1; i < PIPE_DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign strobes.advance = advance;
  assign strobes.doRead  = (stg[LAST].kind == OP_READ);
  assign strobes.doWrite = (stg[LAST].kind == OP_WRITE);
  assign tailAddr        = stg[LAST].a;

  // R1: an inactive chip enable with a load yields a deselect
  p_deselect_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !loadN && (chipEn1N || !chipEn2 || chipEn3N) |=> stg[0].kind == OP_IDLE);

  // R5: a continue stays inside the aligned group, keeps direction, moves the beat
  p_burst_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance && loadN && stg[0].kind != OP_IDLE |=>
      stg[0].a[ADDR_W-1:BEAT_BITS] == $past(stg[0].a[ADDR_W-1:BEAT_BITS]) &&
      stg[0].kind == $past(stg[0].kind) &&
      stg[0].a[BEAT_BITS-1:0] != $past(stg[0].a[BEAT_BITS-1:0]));

  // R6: continuing a deselect remains a deselect
  p_idle_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    advance && loadN && stg[0].kind == OP_IDLE |=> stg[0].kind == OP_IDLE);

  // R7: suspend freezes the pipeline
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clkEnN |=> $stable(stg[LAST]) && $stable(stg[0]));

endmodule

// File: rtl/pipe_sram_dp.sv
module pipe_sram_dp
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobeT                  strobes,
  input  logic [ADDR_W-1:0]         tailAddr,
  input  logic [LANES-1:0]          byteWeN,
  input  logic [LANES*LANE_W-1:0]   dqIn,
  output logic [LANES*LANE_W-1:0]   dqOut,
  output logic                      dqOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic laneWrite;
  logic laneRead;

  assign laneWrite = strobes.advance && strobes.doWrite;
  assign laneRead  = strobes.advance && strobes.doRead;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (laneWrite && !byteWeN[g])
        laneMem[tailAddr] <= dqIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        laneOut <= '0;
      else if (laneRead) laneOut <= laneMem[tailAddr];
    end

    assign dqOut[g*LANE_W +: LANE_W] = laneOut;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               dqOe <= 1'b0;
    else if (strobes.advance) dqOe <= strobes.doRead;
  end

  // R3: the bus only starts driving on an enabled read data phase
  p_drive_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqOe) |-> $past(strobes.advance && strobes.doRead));

  // R7: outputs hold across a suspend
  p_hold_on_suspend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.advance |=> $stable(dqOut) && $stable(dqOe));

  // R9: a write or idle data phase releases the bus
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.advance && !strobes.doRead |=> !dqOe);

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clkEnN,
  input  logic                    chipEn1N,
  input  logic                    chipEn2,
  input  logic                    chipEn3N,
  input  logic                    loadN,
  input  logic                    readNotWrite,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);

  localparam int BEAT_BITS  = 2;
  localparam int PIPE_DEPTH = 2;

  dpStrobeT          strobes;
  logic [ADDR_W-1:0] tailAddr;

  pipe_sram_ctrl #(
    .ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS), .PIPE_DEPTH(PIPE_DEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .loadN(loadN), .readNotWrite(readNotWrite), .addr(addr),
    .strobes(strobes), .tailAddr(tailAddr)
  );

  pipe_sram_dp #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .tailAddr(tailAddr),
    .byteWeN(byteWeN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic clkEnN, chipEn1N, chipEn2, chipEn3N, loadN, readNotWrite;
  logic [LANES-1:0]  byteWeN;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     dqIn, dqOut;
  logic              dqOe;

  always #2 clk = ~clk;

  pipe_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_pipe_sram (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .loadN(loadN), .readNotWrite(readNotWrite), .byteWeN(byteWeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  int checks = 0;
  int errors = 0;

  // Reference: array, two-entry operation queue (0 idle, 1 read, 2 write), burst state.
  logic [DW-1:0] refMem [DEPTH];
  int            pKind [2];
  int            pAddr [2];
  string         pTag  [2];
  int            bKind, bAddr;
  logic          expOe;
  logic [DW-1:0] expOut;

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(a * 40503 + k * 977 + 7) ^ (DW'(k) << 27);
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ceMode: 0 all enables active, 1 chipEn1N high, 2 chipEn2 low, 3 chipEn3N high
  task automatic step(bit cen, bit ld, int ceMode, bit rw, logic [LANES-1:0] be,
                      int a, logic [DW-1:0] d, string tag);
    int    iK, iA;
    string tt;
    @(negedge clk);
    clkEnN = cen; loadN = ld; readNotWrite = rw; byteWeN = be;
    chipEn1N = (ceMode == 1); chipEn2 = (ceMode != 2); chipEn3N = (ceMode == 3);
    addr = ADDR_W'(a); dqIn = d;
    @(posedge clk);
    tt = "R7";
    if (!cen) begin
      tt = pTag[1];
      if (pKind[1] == 1) begin
        expOe = 1'b1; expOut = refMem[pAddr[1]];
      end else begin
        expOe = 1'b0;
        if (pKind[1] == 2)
          for (int l = 0; l < LANES; l++)
            if (!be[l]) refMem[pAddr[1]][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      end
      if (!ld) begin
        iK = (ceMode == 0) ? (rw ? 1 : 2) : 0;
        iA = a;
      end else begin
        iK = bKind;
        iA = (bAddr & ~3) | ((bAddr + 1) & 3);
      end
      bKind = iK; bAddr = iA;
      pKind[1] = pKind[0]; pAddr[1] = pAddr[0]; pTag[1] = pTag[0];
      pKind[0] = iK;       pAddr[0] = iA;       pTag[0] = tag;
    end
    #1;
    chk(dqOe === expOe, tt, DW'(dqOe), DW'(expOe));
    if (expOe) chk(dqOut === expOut, tt, dqOut, expOut);
  endtask

  task automatic flush();
    step(0, 0, 1, 0, '1, 0, '0, "R9");
    step(0, 0, 2, 0, '1, 0, '0, "R9");
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin pKind[i] = 0; pAddr[i] = 0; pTag[i] = "R10"; end
    bKind = 0; bAddr = 0; expOe = 1'b0; expOut = '0;
    rst_n = 1'b0; clkEnN = 1'b0; loadN = 1'b0; readNotWrite = 1'b0;
    chipEn1N = 1'b1; chipEn2 = 1'b1; chipEn3N = 1'b0;
    byteWeN = '1; addr = '0; dqIn = '0;
    repeat (3) @(posedge clk);
    #1 chk(dqOe === 1'b0, "R10", DW'(dqOe), '0);
    @(negedge clk) rst_n = 1'b1;
    // R10: first data phases after reset see an empty pipeline (reads issued now)
    step(0, 0, 0, 1, '1, 3, '0, "R10");
    step(0, 0, 0, 1, '1, 4, '0, "R10");
    flush();

    // R2 / R4: fill the whole array with single writes, full masks
    for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 0, '0, a, pat(a - 2, 1), "R4");
    flush();
    // R3: read back everything, back to back
    for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 1, '1, a, '0, "R3");
    flush();

    // R9: write then read the same address on consecutive edges
    for (int a = 0; a < DEPTH / 2; a++) begin
      step(0, 0, 0, 0, '0, a, pat(a, 3), "R9");
      step(0, 0, 0, 1, '0, a, pat(a, 4), "R9");
    end
    flush();

    // R5 / R7 / R8: bursts at every start offset with a mid-burst suspend
    for (int s = 0; s < 4; s++) begin
      int base = 16 + 4 * s + s;
      step(0, 0, 0, 0, 4'(s), base, pat(base, 30), "R5");
      step(0, 1, 1, 1, 4'(s + 5), 0, pat(base, 31), "R8");
      step(1, 1, 0, 1, 4'h0, 9, pat(base, 90), "R7");
      step(1, 0, 0, 0, 4'h0, 9, pat(base, 91), "R7");
      step(0, 1, 2, 1, 4'(s + 9), 0, pat(base, 32), "R8");
      step(0, 1, 3, 0, 4'(s * 3), 0, pat(base, 33), "R5");
      step(0, 0, 0, 1, 4'(s + 2), base & ~3, pat(base, 34), "R5");
      step(0, 1, 3, 0, 4'(s + 7), 0, pat(base, 35), "R5");
      step(1, 1, 0, 0, 4'h0, 0, pat(base, 92), "R7");
      step(0, 1, 1, 0, '1, 0, pat(base, 36), "R5");
      step(0, 1, 0, 0, '1, 0, pat(base, 37), "R5");
      flush();
    end

    // R1 / R6: each deselect encoding, then continues; nothing may be written
    for (int m = 1; m < 4; m++) begin
      step(0, 0, m, 0, '0, 40 + m, pat(40 + m, 50), "R1");
      step(0, 1, 0, 0, '0, 0, pat(m, 51), "R6");
      step(0, 1, 0, 1, '0, 0, pat(m, 52), "R6");
      step(0, 1, 0, 0, '0, 0, pat(m, 53), "R6");
      flush();
    end
    for (int a = 40; a < 48; a++) step(0, 0, 0, 1, '1, a, '0, "R1");
    flush();

    // R8: every mask value on one address, each followed by a read
    for (int mk = 0; mk < 16; mk++) begin
      step(0, 0, 0, 0, 4'(mk), 50, pat(50, 60 + mk), "R8");
      step(0, 0, 0, 1, 4'(mk), 50, pat(50, 60 + mk), "R8");
    end
    flush();
    step(0, 0, 0, 1, '1, 50, '0, "R8");
    flush();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule